// File: doc/BRIEF.md
# Dual-Queue Conversion Command Scheduler

This block sequences an external converter through a table of conversion command words. The table is shared by two queues. Queue 1 always starts at index 0. Queue 2 starts at an index that software programs. Each queue is armed by its own trigger pulse. The scheduler then walks the table in ascending order, issuing one start strobe per command and waiting for the converter's done pulse before it moves on.

Queue 1 outranks queue 2. A queue 1 trigger that lands while a queue 2 command is in flight kills that command at once. When queue 1 has finished, queue 2 picks up again. A resume-select input decides where it picks up: at the first command of its current subqueue, or at the very command that was killed.

Several other controls act on conversions. A mode change, stop mode or debug freeze each affects the conversion in flight in its own way. The end of a queue raises a sticky completion flag, which feeds a maskable interrupt line.

Top module: `conv_queue_sched`

## Requirements
- R1: A command word carries a 6-bit channel field on `cmd_chan_i` and a pause bit on `cmd_pause_i`. Queue 1 starts at index 0 and queue 2 at `q2_begin_i`. Commands issue at ascending indices. A queue ends without a start when its current entry holds channel code 63, or once the command at index 63 has completed. A queue whose first entry is code 63 completes with no start.
- R2: When both queues are pending and the converter is idle, queue 1 issues first. A queue 1 trigger accepted while a queue 2 command is converting raises `conv_abort_o` in that same cycle with no start. Queue 1's first start (index 0) follows in the next cycle.
- R3: With `resume_sel_i`=0, a preempted queue 2 restarts at its subqueue start. The subqueue start is the index after the most recent completed command whose pause bit was set, or `q2_begin_i` if there was none.
- R4: With `resume_sel_i`=1, a preempted queue 2 restarts at the command that was aborted.
- R5: A queue 1 trigger in the same cycle as the done pulse of a queue 2 command causes no abort. That command counts as complete, and after queue 1 finishes, queue 2 continues at the next index.
- R6: Changing a queue's mode (`mode1_i`/`mode2_i`) between two nonzero values has several effects. It aborts that queue's command in flight in the same cycle and idles the queue. A trigger in that cycle is ignored. The next trigger restarts the queue at its first index.
- R7: Mode 0 disables a queue. Entering it aborts the queue's command in flight, and while it holds, triggers neither start the queue nor set its overrun flag.
- R8: While `stop_i` is high, any command in flight is aborted in the first cycle. No start issues, triggers are ignored and both queues are cleared to idle.
- R9: With `frz_en_i` and `frz_i` both high, the command in flight finishes without abort but no new start issues. When freeze drops, execution continues at the next index. `frz_i` alone has no effect.
- R10: `done_flag_o[q]` (bit 0 queue 1, bit 1 queue 2) sets when queue q ends and stays set until a one on `flag_clr_i[q]`; a set wins over a clear. `irq_o` is high exactly when some flag bit and its `irq_en_i` bit are both set.
- R11: A trigger for a queue that is active (including a suspended queue 2) is ignored and sets `ovr_flag_o[q]`. This flag is sticky and is cleared by the same `flag_clr_i[q]` strobe.
- R12: `conv_start_o` is a single-cycle pulse and never coincides with `conv_abort_o`. `conv_done_i` counts only while a command is converting. After an abort, the next start comes no earlier than the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig1_i | input | 1 | Queue 1 trigger pulse |
| trig2_i | input | 1 | Queue 2 trigger pulse |
| mode1_i | input | 2 | Queue 1 mode, 0 disabled |
| mode2_i | input | 2 | Queue 2 mode, 0 disabled |
| resume_sel_i | input | 1 | 1: resume queue 2 at aborted command |
| stop_i | input | 1 | Stop mode |
| frz_en_i | input | 1 | Freeze enable |
| frz_i | input | 1 | Debug freeze request |
| q2_begin_i | input | 6 | First table index of queue 2 |
| irq_en_i | input | 2 | Per-queue interrupt enable |
| flag_clr_i | input | 2 | Write-one-to-clear strobe for flags |
| cmd_chan_i | input | 6 | Channel field of the addressed command |
| cmd_pause_i | input | 1 | Pause bit of the addressed command |
| conv_done_i | input | 1 | Converter done pulse |
| cmd_idx_o | output | 6 | Command table read index |
| conv_start_o | output | 1 | Converter start strobe |
| conv_abort_o | output | 1 | Converter abort strobe |
| done_flag_o | output | 2 | Per-queue completion flags |
| ovr_flag_o | output | 2 | Per-queue trigger overrun flags |
| irq_o | output | 1 | Interrupt request |

## Verification
The contested cycle is the one where a queue 2 done pulse meets a queue 1 trigger. If that pair were misjudged, the scheduler would either abort a finished command or rerun it. The bench watches its converter model. It raises the queue 1 trigger exactly in the cycle the converter reports done on a queue 2 command. It then confirms that no abort appears and that the logged start sequence shows queue 2 resuming one index past that command. The bench then moves the trigger a few cycles earlier into the conversion and checks for the opposite outcome: an abort in the trigger cycle, queue 1 at index 0 in the next cycle, and queue 2 restarting wherever resume-select and the pause position dictate.

// File: rtl/conv_sched_pkg.sv
`timescale 1ns/1ps
package conv_sched_pkg;
  localparam int NQ    = 2;
  localparam int SEL_W = (NQ > 1) ? $clog2(NQ) : 1;
  localparam int Q1    = 0;
  localparam int Q2    = 1;
endpackage

// File: rtl/sched_qctx.sv
`timescale 1ns/1ps
module sched_qctx #(
  parameter int IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] start_idx_i,
  input  logic             clr_i,
  input  logic             trig_acc_i,
  input  logic             eoq_i,
  input  logic             done_i,
  input  logic             pause_i,
  input  logic             preempt_i,
  input  logic             resume_i,
  output logic             active_o,
  output logic [IDX_W-1:0] ptr_o,
  output logic             complete_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = '1;

  logic             active_q;
  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] subq_q;
  logic             at_last;

  assign at_last    = (ptr_q == LAST_IDX);
  assign complete_o = !clr_i && (eoq_i || (done_i && at_last));
  assign active_o   = active_q;
  assign ptr_o      = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      ptr_q    <= '0;
      subq_q   <= '0;
    end else if (clr_i) begin
      active_q <= 1'b0;
      ptr_q    <= start_idx_i;
      subq_q   <= start_idx_i;
    end else if (trig_acc_i) begin
      active_q <= 1'b1;
      ptr_q    <= start_idx_i;
      subq_q   <= start_idx_i;
    end else if (complete_o) begin
      active_q <= 1'b0;
      ptr_q    <= start_idx_i;
      subq_q   <= start_idx_i;
    end else if (done_i) begin
      ptr_q <= ptr_q + 1'b1;
      if (pause_i) subq_q <= ptr_q + 1'b1;
    end else if (preempt_i) begin
      ptr_q <= resume_i ? ptr_q : subq_q;
    end
  end
endmodule

// File: rtl/sched_arb.sv
`timescale 1ns/1ps
module sched_arb
  import conv_sched_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic [NQ-1:0]            req_i,
  input  logic [NQ-1:0][IDX_W-1:0] ptr_i,
  output logic                     valid_o,
  output logic [SEL_W-1:0]         sel_o,
  output logic [IDX_W-1:0]         idx_o
);
  // lowest queue number wins
  always_comb begin
    valid_o = 1'b0;
    sel_o   = '0;
    idx_o   = ptr_i[0];
    for (int q = NQ - 1; q >= 0; q--) begin
      if (req_i[q]) begin
        valid_o = 1'b1;
        sel_o   = SEL_W'(q);
        idx_o   = ptr_i[q];
      end
    end
  end
endmodule

// File: rtl/sched_flags.sv
`timescale 1ns/1ps
module sched_flags
  import conv_sched_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NQ-1:0] set_done_i,
  input  logic [NQ-1:0] set_ovr_i,
  input  logic [NQ-1:0] clr_i,
  input  logic [NQ-1:0] irq_en_i,
  output logic [NQ-1:0] done_o,
  output logic [NQ-1:0] ovr_o,
  output logic          irq_o
);
  for (genvar q = 0; q < NQ; q++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        done_o[q] <= 1'b0;
        ovr_o[q]  <= 1'b0;
      end else begin
        if (set_done_i[q])  done_o[q] <= 1'b1;
        else if (clr_i[q])  done_o[q] <= 1'b0;
        if (set_ovr_i[q])   ovr_o[q]  <= 1'b1;
        else if (clr_i[q])  ovr_o[q]  <= 1'b0;
      end
    end
  end

  assign irq_o = |(done_o & irq_en_i);
endmodule

// File: rtl/conv_queue_sched.sv
`timescale 1ns/1ps
module conv_queue_sched
  import conv_sched_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int CHAN_W = 6,
  parameter int MODE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig1_i,
  input  logic              trig2_i,
  input  logic [MODE_W-1:0] mode1_i,
  input  logic [MODE_W-1:0] mode2_i,
  input  logic              resume_sel_i,
  input  logic              stop_i,
  input  logic              frz_en_i,
  input  logic              frz_i,
  input  logic [IDX_W-1:0]  q2_begin_i,
  input  logic [NQ-1:0]     irq_en_i,
  input  logic [NQ-1:0]     flag_clr_i,
  input  logic [CHAN_W-1:0] cmd_chan_i,
  input  logic              cmd_pause_i,
  input  logic              conv_done_i,
  output logic [IDX_W-1:0]  cmd_idx_o,
  output logic              conv_start_o,
  output logic              conv_abort_o,
  output logic [NQ-1:0]     done_flag_o,
  output logic [NQ-1:0]     ovr_flag_o,
  output logic              irq_o
);
  localparam logic [CHAN_W-1:0] EOQ_CHAN = '1;

  logic [NQ-1:0][MODE_W-1:0] mode_cur, mode_q;
  logic [NQ-1:0][IDX_W-1:0]  ptr;
  logic [NQ-1:0] trig, mode_chg, enabled, trig_ok, trig_acc, ovr_set;
  logic [NQ-1:0] active, req, done_q, eoq_q, pre_q, clr_q, complete;
  logic          busy_q, pause_q;
  logic [SEL_W-1:0] owner_q, sel;
  logic          sel_valid, frozen, done_ev, preempt, kill, abort;
  logic          issue_ok, eoq_hit, start;

  assign mode_cur = {mode2_i, mode1_i};
  assign trig     = {trig2_i, trig1_i};
  assign frozen   = frz_en_i & frz_i;

  always_comb begin
    for (int q = 0; q < NQ; q++) begin
      mode_chg[q] = (mode_cur[q] != mode_q[q]);
      enabled[q]  = |mode_cur[q];
      trig_ok[q]  = trig[q] & enabled[q] & ~mode_chg[q] & ~stop_i;
      trig_acc[q] = trig_ok[q] & ~active[q];
      ovr_set[q]  = trig_ok[q] & active[q];
      req[q]      = active[q] & ~mode_chg[q];
      clr_q[q]    = mode_chg[q] | stop_i;
    end
  end

  assign done_ev = busy_q & conv_done_i;
  // a finishing command is never aborted
  assign preempt = busy_q & ~conv_done_i & (owner_q == SEL_W'(Q2)) & trig_acc[Q1];
  assign kill    = busy_q & ~conv_done_i & (stop_i | mode_chg[owner_q]);
  assign abort   = preempt | kill;

  assign issue_ok = ~busy_q & ~stop_i & ~frozen & ~trig_acc[Q1] & sel_valid;
  assign eoq_hit  = (cmd_chan_i == EOQ_CHAN);
  assign start    = issue_ok & ~eoq_hit;

  always_comb begin
    for (int q = 0; q < NQ; q++) begin
      done_q[q] = done_ev & (owner_q == SEL_W'(q));
      eoq_q[q]  = issue_ok & eoq_hit & (sel == SEL_W'(q));
      pre_q[q]  = (q == Q2) ? preempt : 1'b0;
    end
  end

  sched_arb #(.IDX_W(IDX_W)) u_arb (
    .req_i   (req),
    .ptr_i   (ptr),
    .valid_o (sel_valid),
    .sel_o   (sel),
    .idx_o   (cmd_idx_o)
  );

  for (genvar q = 0; q < NQ; q++) begin : g_q
    logic [IDX_W-1:0] base;
    if (q == Q1) begin : g_fixed
      assign base = '0;
    end else begin : g_prog
      assign base = q2_begin_i;
    end
    sched_qctx #(.IDX_W(IDX_W)) u_qctx (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .start_idx_i (base),
      .clr_i       (clr_q[q]),
      .trig_acc_i  (trig_acc[q]),
      .eoq_i       (eoq_q[q]),
      .done_i      (done_q[q]),
      .pause_i     (pause_q),
      .preempt_i   (pre_q[q]),
      .resume_i    (resume_sel_i),
      .active_o    (active[q]),
      .ptr_o       (ptr[q]),
      .complete_o  (complete[q])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      busy_q  <= 1'b0;
      owner_q <= '0;
      pause_q <= 1'b0;
    end else begin
      mode_q <= mode_cur;
      if (abort || done_ev) begin
        busy_q <= 1'b0;
      end else if (start) begin
        busy_q  <= 1'b1;
        owner_q <= sel;
        pause_q <= cmd_pause_i;
      end
    end
  end

  sched_flags u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_done_i (complete),
    .set_ovr_i  (ovr_set),
    .clr_i      (flag_clr_i),
    .irq_en_i   (irq_en_i),
    .done_o     (done_flag_o),
    .ovr_o      (ovr_flag_o),
    .irq_o      (irq_o)
  );

  assign conv_start_o = start;
  assign conv_abort_o = abort;
endmodule

// File: rtl/sched_chk.sv
`timescale 1ns/1ps
module sched_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       stop_i,
  input logic       frz_en_i,
  input logic       frz_i,
  input logic [1:0] irq_en_i,
  input logic [1:0] flag_clr_i,
  input logic       conv_start_o,
  input logic       conv_abort_o,
  input logic [1:0] done_flag_o,
  input logic [1:0] ovr_flag_o,
  input logic       irq_o
);
  assert_no_start_with_abort_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(conv_start_o && conv_abort_o));
  assert_single_start_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o);
  assert_abort_once_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_abort_o |=> !conv_abort_o);
  assert_stop_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |-> !conv_start_o);
  assert_freeze_blocks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frz_en_i && frz_i) |-> !conv_start_o);
  assert_freeze_no_abort_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frz_en_i && frz_i && !stop_i && $stable(frz_i)) |-> !conv_abort_o || !$past(conv_start_o));
  assert_done_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_flag_o[0] && !flag_clr_i[0]) |=> done_flag_o[0]);
  assert_done2_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_flag_o[1] && !flag_clr_i[1]) |=> done_flag_o[1]);
  assert_irq_source_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> |(done_flag_o & irq_en_i));
  assert_ovr_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_flag_o[1] && !flag_clr_i[1]) |=> ovr_flag_o[1]);
endmodule

bind conv_queue_sched sched_chk u_sched_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .stop_i       (stop_i),
  .frz_en_i     (frz_en_i),
  .frz_i        (frz_i),
  .irq_en_i     (irq_en_i),
  .flag_clr_i   (flag_clr_i),
  .conv_start_o (conv_start_o),
  .conv_abort_o (conv_abort_o),
  .done_flag_o  (done_flag_o),
  .ovr_flag_o   (ovr_flag_o),
  .irq_o        (irq_o)
);

// File: tb/test_conv_queue_sched.sv
`timescale 1ns/1ps
module test_conv_queue_sched;
  localparam int LAT = 3;
  localparam int EOQ = 63;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       trig1 = 0, trig2 = 0, resume_sel = 0, stop = 0, frz_en = 0, frz = 0;
  logic [1:0] mode1 = 2'd1, mode2 = 2'd1, irq_en = 2'b11, flag_clr = 2'b00;
  logic [5:0] q2_begin = 6'd16;
  logic [5:0] tbl_chan [64];
  logic       tbl_pause [64];
  logic [5:0] cmd_idx, cmd_chan;
  logic       cmd_pause, conv_start, conv_abort, conv_done;
  logic [1:0] done_flag, ovr_flag;
  logic       irq;

  int n_chk = 0, n_fail = 0;
  int log_arr [256];
  int exp_arr [256];
  int log_n = 0, exp_n = 0, abort_n = 0, cnv_cnt = 0;

  always #5 clk = ~clk;

  assign cmd_chan  = tbl_chan[cmd_idx];
  assign cmd_pause = tbl_pause[cmd_idx];

  conv_queue_sched i_conv_queue_sched (
    .clk_i(clk), .rst_ni(rst_n), .trig1_i(trig1), .trig2_i(trig2),
    .mode1_i(mode1), .mode2_i(mode2), .resume_sel_i(resume_sel), .stop_i(stop),
    .frz_en_i(frz_en), .frz_i(frz), .q2_begin_i(q2_begin), .irq_en_i(irq_en),
    .flag_clr_i(flag_clr), .cmd_chan_i(cmd_chan), .cmd_pause_i(cmd_pause),
    .conv_done_i(conv_done), .cmd_idx_o(cmd_idx), .conv_start_o(conv_start),
    .conv_abort_o(conv_abort), .done_flag_o(done_flag), .ovr_flag_o(ovr_flag), .irq_o(irq)
  );

  // converter model: done LAT+1 edges after start unless aborted
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnv_cnt <= 0; conv_done <= 1'b0;
    end else begin
      conv_done <= (cnv_cnt == 1) && !conv_abort;
      if (conv_abort) cnv_cnt <= 0;
      else if (conv_start) cnv_cnt <= LAT;
      else if (cnv_cnt > 0) cnv_cnt <= cnv_cnt - 1;
    end
  end

  // monitor, sampled late in the low phase
  always @(negedge clk) begin
    #4;
    if (rst_n && conv_start) begin log_arr[log_n] = int'(cmd_idx); log_n++; end
    if (rst_n && conv_abort) abort_n++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic fill_tbl();
    for (int i = 0; i < 64; i++) begin tbl_chan[i] = 6'(i % 32); tbl_pause[i] = 1'b0; end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic new_log();
    log_n = 0; exp_n = 0;
  endtask

  task automatic expv(input int v);
    exp_arr[exp_n] = v; exp_n++;
  endtask

  task automatic exp_range(input int a, input int b);
    for (int v = a; v <= b; v++) expv(v);
  endtask

  task automatic chk_log(input string req);
    chk(log_n == exp_n, {req, " start count"}, log_n, exp_n);
    for (int i = 0; i < exp_n && i < log_n; i++)
      chk(log_arr[i] == exp_arr[i], {req, " start index"}, log_arr[i], exp_arr[i]);
  endtask

  task automatic pulse(input int q);
    @(negedge clk);
    if (q == 1) trig1 = 1'b1; else trig2 = 1'b1;
    @(negedge clk);
    trig1 = 1'b0; trig2 = 1'b0;
  endtask

  task automatic clr_flags();
    @(negedge clk); flag_clr = 2'b11;
    @(negedge clk); flag_clr = 2'b00;
  endtask

  task automatic wait_log(input int n);
    while (log_n < n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    fill_tbl();
    cyc(3);
    rst_n = 1'b1;
    cyc(3);
    #1;
    // reset state
    chk(conv_start == 0 && conv_abort == 0, "R12 reset strobes", int'(conv_start), 0);
    chk(done_flag == 0 && ovr_flag == 0, "R10 reset flags", int'(done_flag), 0);
    chk(irq == 0, "R10 reset irq", int'(irq), 0);

    // R1: queue 1 length sweep including empty queue
    for (int n1 = 0; n1 < 4; n1++) begin
      fill_tbl(); tbl_chan[n1] = EOQ;
      new_log(); pulse(1); cyc(40);
      exp_range(0, n1 - 1);
      chk_log("R1 q1 sweep");
      chk(done_flag[0] == 1, "R10 q1 flag", int'(done_flag[0]), 1);
      chk(irq == 1, "R10 irq on", int'(irq), 1);
      clr_flags(); #1;
      chk(done_flag == 0 && irq == 0, "R10 w1c clear", int'(done_flag), 0);
    end

    // R10: masked interrupt
    irq_en = 2'b10;
    new_log(); pulse(1); cyc(40);
    chk(done_flag[0] == 1 && irq == 0, "R10 masked irq", int'(irq), 0);
    irq_en = 2'b11; clr_flags();

    // R1: queue 2 begin sweep
    for (int k = 0; k < 3; k++) begin
      int b;
      b = 8 + 16 * k;
      fill_tbl(); tbl_chan[b + 3] = EOQ; q2_begin = 6'(b);
      new_log(); pulse(2); cyc(40);
      exp_range(b, b + 2);
      chk_log("R1 q2 sweep");
      chk(done_flag[1] == 1, "R10 q2 flag", int'(done_flag[1]), 1);
      clr_flags();
    end

    // R1: end at index 63
    fill_tbl(); q2_begin = 6'd62;
    new_log(); pulse(2); cyc(40);
    exp_range(62, 63);
    chk_log("R1 last index");
    chk(done_flag[1] == 1, "R1 last index flag", int'(done_flag[1]), 1);
    clr_flags();

    // R2: simultaneous triggers
    fill_tbl(); tbl_chan[2] = EOQ; tbl_chan[18] = EOQ; q2_begin = 6'd16;
    new_log();
    @(negedge clk); trig1 = 1; trig2 = 1;
    @(negedge clk); trig1 = 0; trig2 = 0;
    cyc(50);
    exp_range(0, 1); exp_range(16, 17);
    chk_log("R2 priority");
    clr_flags();

    // R2 R3 R4 R11: preemption sweep over resume select and pause position
    for (int r = 0; r < 2; r++) begin
      for (int p = 0; p < 2; p++) begin
        fill_tbl(); tbl_chan[2] = EOQ; tbl_chan[22] = EOQ;
        tbl_pause[17] = 1'(p);
        resume_sel = 1'(r);
        new_log(); pulse(2);
        wait_log(4);
        @(negedge clk); trig1 = 1; #1;
        chk(conv_abort == 1, "R2 preempt abort", int'(conv_abort), 1);
        chk(conv_start == 0, "R12 no start on abort", int'(conv_start), 0);
        @(negedge clk); trig1 = 0; #1;
        chk(conv_start == 1 && cmd_idx == 0, "R2 q1 next cycle", int'(cmd_idx), 0);
        pulse(2);
        cyc(70);
        exp_range(16, 19); exp_range(0, 1);
        exp_range((r == 1) ? 19 : ((p == 1) ? 18 : 16), 21);
        chk_log(r == 1 ? "R4 resume at aborted" : "R3 resume at subqueue");
        chk(ovr_flag[1] == 1, "R11 suspended overrun", int'(ovr_flag[1]), 1);
        clr_flags(); #1;
        chk(ovr_flag == 0, "R11 overrun clear", int'(ovr_flag), 0);
      end
    end

    // R5: queue 1 trigger in the done cycle of a queue 2 command
    resume_sel = 0;
    fill_tbl(); tbl_chan[2] = EOQ; tbl_chan[22] = EOQ;
    new_log(); pulse(2);
    wait_log(2);
    while (!conv_done) @(negedge clk);
    trig1 = 1; #1;
    chk(conv_abort == 0, "R5 no abort on done", int'(conv_abort), 0);
    @(negedge clk); trig1 = 0;
    cyc(70);
    exp_range(16, 17); exp_range(0, 1); exp_range(18, 21);
    chk_log("R5 coincident done");
    clr_flags();

    // R6: mode change aborts, same-cycle trigger ignored
    new_log(); pulse(2);
    wait_log(2);
    @(negedge clk); mode2 = 2'd2; trig2 = 1; #1;
    chk(conv_abort == 1, "R6 mode change abort", int'(conv_abort), 1);
    @(negedge clk); trig2 = 0;
    cyc(30);
    chk(log_n == 2, "R6 queue idle", log_n, 2);
    chk(ovr_flag[1] == 0, "R6 trigger ignored", int'(ovr_flag[1]), 0);
    pulse(2); cyc(60);
    exp_range(16, 17); exp_range(16, 21);
    chk_log("R6 restart at begin");
    clr_flags();

    // R7: disable
    new_log(); pulse(2);
    wait_log(1);
    @(negedge clk); mode2 = 2'd0; #1;
    chk(conv_abort == 1, "R7 disable abort", int'(conv_abort), 1);
    cyc(5); clr_flags();
    pulse(2); cyc(30);
    chk(log_n == 1, "R7 no start when disabled", log_n, 1);
    chk(ovr_flag[1] == 0 && done_flag[1] == 0, "R7 no flags", int'(ovr_flag[1]), 0);
    mode2 = 2'd1; cyc(3);

    // R8: stop
    new_log(); pulse(1);
    wait_log(1);
    @(negedge clk); stop = 1; #1;
    chk(conv_abort == 1, "R8 stop abort", int'(conv_abort), 1);
    pulse(1); pulse(2); cyc(10);
    stop = 0; cyc(30);
    chk(log_n == 1, "R8 halted", log_n, 1);
    chk(ovr_flag == 0 && done_flag == 0, "R8 triggers ignored", int'(ovr_flag), 0);
    pulse(1); cyc(30);
    expv(0); exp_range(0, 1);
    chk_log("R8 restart");
    clr_flags();

    // R9: freeze without enable has no effect
    frz = 1;
    new_log(); pulse(1); cyc(40);
    exp_range(0, 1);
    chk_log("R9 freeze disabled");
    frz = 0; frz_en = 1; clr_flags();
    // R9: freeze holds after current command
    new_log(); abort_n = 0; pulse(1);
    wait_log(1);
    @(negedge clk); frz = 1;
    cyc(30);
    chk(log_n == 1, "R9 held while frozen", log_n, 1);
    chk(abort_n == 0, "R9 no abort", abort_n, 0);
    @(negedge clk); frz = 0;
    cyc(30);
    exp_range(0, 1);
    chk_log("R9 resume next");
    frz_en = 0; clr_flags();

    finish_run();
  end
endmodule